// File: doc/BRIEF.md
# Immediate Instruction Sequencer

This block is the front end of a small byte-coded stack processor. A start request carries an entry address. The block then reads one opcode byte per instruction from a byte-wide memory at its program counter. Each opcode is either an ordinary operation or a member of the immediate group. An immediate opcode is one whose five low bits are all zero, and its three high bits choose the instruction. The block carries out the immediate group itself: break, three jumps that take an inline 16-bit offset, and literal pushes of one or two inline bytes onto either the working stack or the return stack. It hands each ordinary operation to an external execution unit and waits until that unit finishes.

Memory is read combinationally, one byte per cycle. Instructions with a two-byte operand therefore spend two cycles gathering it. Stack traffic leaves the block as single-byte push strobes and one pop strobe on the working stack, and the stack presents its current top byte on `popData`. A run ends in one of three ways: a break opcode, a halt raised by any unit, or a refused start. The block reports the outcome as a one-cycle completion pulse with a status code. After a halt, the block also reports the address of the opcode that faulted.

Top module: `imm_sequencer`

## Requirements
- R1: A start request whose entry address is zero, or that arrives while `stopFlag` is high, fetches nothing. It gives `doneValid` in the next cycle with `doneStatus` = 3 (refused), and `busy` stays low.
- R2: A start request with a non-zero address and `stopFlag` low raises `busy`, and the first fetch is at the entry address. Each fetch moves the program counter to the next byte before any operand byte is read.
- R3: Opcode 0x00 (break) ends the run. `doneValid` pulses one cycle after the fetch with `doneStatus` = 1, and `busy` falls.
- R4: Opcodes 0x80 and 0xC0 push the next memory byte, with `pushRet` = 0 for 0x80 (working stack) and 1 for 0xC0 (return stack). They advance the program counter by two and take two cycles.
- R5: Opcodes 0xA0 and 0xE0 push the next two bytes, the first byte in memory first. `pushRet` follows bit 6 of the opcode. They advance the program counter by three and take five cycles.
- R6: Opcode 0x40 jumps to (address after the two operand bytes) + (operand read high byte first), modulo 2^16, in three cycles.
- R7: Opcode 0x20 raises `popReq` in its fetch cycle and tests `popData`. A zero byte skips the two operand bytes in one cycle. Any other value jumps as in R6.
- R8: Opcode 0x60 pushes the address after its operand onto the return stack, high byte then low byte, and then jumps as in R6. It takes five cycles.
- R9: Any opcode with a non-zero low five bits is handed to the execution unit. `opValid` pulses for one cycle with `opCode` = bits 4:0, `opShort` = bit 5, `opRet` = bit 6 and `opKeep` = bit 7. The block then waits for `opDone`, and `opJump` high with `opDone` loads `opTarget` into the program counter.
- R10: `haltIn` while busy ends the run with `doneStatus` = 2, and `faultPc` holds the address of the last opcode fetched.
- R11: While idle, `pushValid`, `popReq` and `opValid` stay low. `pushValid` and `opValid` are never high together.
- R12: `doneValid` is a single-cycle pulse, and `busy` is low whenever it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Begin a run at `startPc` |
| startPc | input | 16 | Entry address |
| stopFlag | input | 1 | Refuses a start while high |
| memAddr | output | 16 | Memory read address (the program counter) |
| memData | input | 8 | Byte at `memAddr`, combinational |
| popReq | output | 1 | Pop one byte from the working stack |
| popData | input | 8 | Current top byte of the working stack |
| pushValid | output | 1 | Push `pushData` this cycle |
| pushRet | output | 1 | 1 selects the return stack, 0 the working stack |
| pushData | output | 8 | Byte to push |
| opValid | output | 1 | Ordinary operation issued |
| opCode | output | 5 | Operation number |
| opShort | output | 1 | Two-byte operand mode |
| opRet | output | 1 | Operate on return stack |
| opKeep | output | 1 | Keep operands mode |
| opDone | input | 1 | Execution unit finished |
| opJump | input | 1 | With `opDone`: load `opTarget` |
| opTarget | input | 16 | New program counter from execution unit |
| haltIn | input | 1 | Fault from any unit |
| busy | output | 1 | Run in progress |
| doneValid | output | 1 | Run finished (pulse) |
| doneStatus | output | 2 | 1 break, 2 halt, 3 refused |
| faultPc | output | 16 | Address of last fetched opcode |

## Verification
The bound checker watches the handshake rules on every cycle. It covers the quiet outputs while idle, the exclusion between pushes and issued operations, the single-cycle completion pulse and the idle state that follows it, the spacing between issued operations, and the first fetch landing on the entry address. Only the bench scenarios can show the instruction-level outcomes: jump targets with negative offsets, the skip taken on a zero condition byte, the order of pushed bytes, the return address, the per-instruction cycle counts and the fault address. The bench's reference interpreter predicts these for each program and compares them event by event.

// File: rtl/imm_seq_pkg.sv
package imm_seq_pkg;

  typedef enum logic [2:0] {
    PC_HOLD, PC_START, PC_INC, PC_SKIP, PC_REL, PC_EXT
  } pcSel_e;

  typedef enum logic [1:0] {
    W_HOLD, W_OPERAND, W_RETURN
  } wordSel_e;

  typedef enum logic [1:0] {
    PS_MEM, PS_HI, PS_LO
  } pushSrc_e;

  typedef enum logic [1:0] {
    DONE_NONE = 2'd0, DONE_BREAK = 2'd1, DONE_HALT = 2'd2, DONE_REFUSED = 2'd3
  } doneStatus_e;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_OPHI, S_OPLO, S_LITB, S_PUSHHI, S_PUSHLO, S_EXEC
  } seqState_e;

  // immediate group, selected by opcode bits 7:5 when bits 4:0 are zero
  localparam logic [2:0] IMM_BRK   = 3'd0;
  localparam logic [2:0] IMM_JCOND = 3'd1;
  localparam logic [2:0] IMM_JUMP  = 3'd2;
  localparam logic [2:0] IMM_CALL  = 3'd3;
  localparam logic [2:0] IMM_LITW  = 3'd4;
  localparam logic [2:0] IMM_LIT2W = 3'd5;
  localparam logic [2:0] IMM_LITR  = 3'd6;
  localparam logic [2:0] IMM_LIT2R = 3'd7;

  typedef struct packed {
    pcSel_e   pcSel;
    wordSel_e wordSel;
    pushSrc_e pushSrc;
    logic     insLoad;
    logic     hiLoad;
  } seqStrobes_t;

endpackage

// File: rtl/imm_seq_datapath.sv
module imm_seq_datapath
  import imm_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobes_t       strobes,
  input  logic [ADDR_W-1:0] startPc,
  input  logic [DATA_W-1:0] memData,
  input  logic [ADDR_W-1:0] opTarget,
  output logic [ADDR_W-1:0] pc,
  output logic [DATA_W-1:0] insByte,
  output logic [ADDR_W-1:0] opcPc,
  output logic [DATA_W-1:0] pushByte
);

  localparam int WORD_W = 2 * DATA_W;

  logic [DATA_W-1:0] hiReg;
  logic [WORD_W-1:0] wordReg;
  logic [WORD_W-1:0] operandWord;

  assign operandWord = {hiReg, memData};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pc      <= '0;
      insByte <= '0;
      opcPc   <= '0;
      hiReg   <= '0;
      wordReg <= '0;
    end else begin
      unique case (strobes.pcSel)
        PC_START: pc <= startPc;
        PC_INC:   pc <= pc + ADDR_W'(1);
        PC_SKIP:  pc <= pc + ADDR_W'(3);
        PC_REL:   pc <= pc + ADDR_W'(1) + ADDR_W'(operandWord);
        PC_EXT:   pc <= opTarget;
        default:  pc <= pc;
      endcase
      if (strobes.insLoad) begin
        insByte <= memData;
        opcPc   <= pc;
      end
      if (strobes.hiLoad) hiReg <= memData;
      unique case (strobes.wordSel)
        W_OPERAND: wordReg <= operandWord;
        W_RETURN:  wordReg <= WORD_W'(pc + ADDR_W'(1));
        default:   wordReg <= wordReg;
      endcase
    end
  end

  always_comb begin
    unique case (strobes.pushSrc)
      PS_HI:   pushByte = wordReg[WORD_W-1:DATA_W];
      PS_LO:   pushByte = wordReg[DATA_W-1:0];
      default: pushByte = memData;
    endcase
  end

endmodule

// File: rtl/imm_seq_ctrl.sv
module imm_seq_ctrl
  import imm_seq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic              startPcZero,
  input  logic              stopFlag,
  input  logic [DATA_W-1:0] memData,
  input  logic [DATA_W-1:0] insByte,
  input  logic [DATA_W-1:0] popData,
  input  logic              opDone,
  input  logic              opJump,
  input  logic              haltIn,
  output seqStrobes_t       strobes,
  output logic              popReq,
  output logic              pushValid,
  output logic              pushRet,
  output logic              opValid,
  output logic [4:0]        opCode,
  output logic              opShort,
  output logic              opRet,
  output logic              opKeep,
  output logic              busy,
  output logic              doneValid,
  output logic [1:0]        doneStatus
);

  seqState_e   state, stateNext;
  logic        pushRetReg, pushRetNext;
  logic        doneNow;
  doneStatus_e doneCode;
  logic [2:0]  fetchGroup, heldGroup;
  logic        fetchImm;

  assign fetchGroup = memData[7:5];
  assign heldGroup  = insByte[7:5];
  assign fetchImm   = (memData[4:0] == 5'd0);

  assign opCode  = memData[4:0];
  assign opShort = memData[5];
  assign opRet   = memData[6];
  assign opKeep  = memData[7];
  assign busy    = (state != S_IDLE);

  always_comb begin
    stateNext   = state;
    pushRetNext = pushRetReg;
    strobes     = '{pcSel: PC_HOLD, wordSel: W_HOLD, pushSrc: PS_MEM,
                    insLoad: 1'b0, hiLoad: 1'b0};
    popReq      = 1'b0;
    pushValid   = 1'b0;
    pushRet     = 1'b0;
    opValid     = 1'b0;
    doneNow     = 1'b0;
    doneCode    = DONE_NONE;

    unique case (state)
      S_IDLE: begin
        if (startReq) begin
          if (startPcZero || stopFlag) begin
            doneNow  = 1'b1;
            doneCode = DONE_REFUSED;
          end else begin
            strobes.pcSel = PC_START;
            stateNext     = S_FETCH;
          end
        end
      end
      S_FETCH: begin
        strobes.insLoad = 1'b1;
        strobes.pcSel   = PC_INC;
        if (fetchImm) begin
          unique case (fetchGroup)
            IMM_BRK: begin
              doneNow   = 1'b1;
              doneCode  = DONE_BREAK;
              stateNext = S_IDLE;
            end
            IMM_JCOND: begin
              popReq = 1'b1;
              if (popData == '0) strobes.pcSel = PC_SKIP;
              else               stateNext     = S_OPHI;
            end
            IMM_LITW, IMM_LITR: stateNext = S_LITB;
            default:            stateNext = S_OPHI;
          endcase
        end else begin
          opValid   = 1'b1;
          stateNext = S_EXEC;
        end
      end
      S_OPHI: begin
        strobes.hiLoad = 1'b1;
        strobes.pcSel  = PC_INC;
        stateNext      = S_OPLO;
      end
      S_OPLO: begin
        unique case (heldGroup)
          IMM_CALL: begin
            strobes.pcSel   = PC_REL;
            strobes.wordSel = W_RETURN;
            pushRetNext     = 1'b1;
            stateNext       = S_PUSHHI;
          end
          IMM_LIT2W, IMM_LIT2R: begin
            strobes.pcSel   = PC_INC;
            strobes.wordSel = W_OPERAND;
            pushRetNext     = insByte[6];
            stateNext       = S_PUSHHI;
          end
          default: begin
            strobes.pcSel = PC_REL;
            stateNext     = S_FETCH;
          end
        endcase
      end
      S_LITB: begin
        pushValid       = 1'b1;
        pushRet         = insByte[6];
        strobes.pushSrc = PS_MEM;
        strobes.pcSel   = PC_INC;
        stateNext       = S_FETCH;
      end
      S_PUSHHI: begin
        pushValid       = 1'b1;
        pushRet         = pushRetReg;
        strobes.pushSrc = PS_HI;
        stateNext       = S_PUSHLO;
      end
      S_PUSHLO: begin
        pushValid       = 1'b1;
        pushRet         = pushRetReg;
        strobes.pushSrc = PS_LO;
        stateNext       = S_FETCH;
      end
      S_EXEC: begin
        if (opDone) begin
          if (opJump) strobes.pcSel = PC_EXT;
          stateNext = S_FETCH;
        end
      end
      default: stateNext = S_IDLE;
    endcase

    // a fault from any unit overrides every action of the current cycle
    if (haltIn && state != S_IDLE) begin
      strobes   = '{pcSel: PC_HOLD, wordSel: W_HOLD, pushSrc: PS_MEM,
                    insLoad: 1'b0, hiLoad: 1'b0};
      popReq    = 1'b0;
      pushValid = 1'b0;
      opValid   = 1'b0;
      doneNow   = 1'b1;
      doneCode  = DONE_HALT;
      stateNext = S_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= S_IDLE;
      pushRetReg <= 1'b0;
      doneValid  <= 1'b0;
      doneStatus <= DONE_NONE;
    end else begin
      state      <= stateNext;
      pushRetReg <= pushRetNext;
      doneValid  <= doneNow;
      if (doneNow) doneStatus <= doneCode;
    end
  end

endmodule

// File: rtl/imm_sequencer.sv
module imm_sequencer
  import imm_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [ADDR_W-1:0] startPc,
  input  logic              stopFlag,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [DATA_W-1:0] memData,
  output logic              popReq,
  input  logic [DATA_W-1:0] popData,
  output logic              pushValid,
  output logic              pushRet,
  output logic [DATA_W-1:0] pushData,
  output logic              opValid,
  output logic [4:0]        opCode,
  output logic              opShort,
  output logic              opRet,
  output logic              opKeep,
  input  logic              opDone,
  input  logic              opJump,
  input  logic [ADDR_W-1:0] opTarget,
  input  logic              haltIn,
  output logic              busy,
  output logic              doneValid,
  output logic [1:0]        doneStatus,
  output logic [ADDR_W-1:0] faultPc
);

  seqStrobes_t       strobes;
  logic [DATA_W-1:0] insByte;

  imm_seq_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startReq   (startReq),
    .startPcZero(startPc == '0),
    .stopFlag   (stopFlag),
    .memData    (memData),
    .insByte    (insByte),
    .popData    (popData),
    .opDone     (opDone),
    .opJump     (opJump),
    .haltIn     (haltIn),
    .strobes    (strobes),
    .popReq     (popReq),
    .pushValid  (pushValid),
    .pushRet    (pushRet),
    .opValid    (opValid),
    .opCode     (opCode),
    .opShort    (opShort),
    .opRet      (opRet),
    .opKeep     (opKeep),
    .busy       (busy),
    .doneValid  (doneValid),
    .doneStatus (doneStatus)
  );

  imm_seq_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .startPc (startPc),
    .memData (memData),
    .opTarget(opTarget),
    .pc      (memAddr),
    .insByte (insByte),
    .opcPc   (faultPc),
    .pushByte(pushData)
  );

endmodule

// File: rtl/imm_sequencer_chk.sv
module imm_sequencer_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              startReq,
  input logic [ADDR_W-1:0] startPc,
  input logic [ADDR_W-1:0] memAddr,
  input logic              popReq,
  input logic              pushValid,
  input logic              opValid,
  input logic              busy,
  input logic              doneValid,
  input logic [1:0]        doneStatus
);

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!pushValid && !popReq && !opValid));

  // R11
  push_op_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(pushValid && opValid));

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);

  // R12
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> (!busy && doneStatus != 2'd0));

  // R9
  op_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    opValid |=> !opValid);

  // R2
  first_fetch_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (memAddr == $past(startPc) && $past(startReq)));

endmodule

bind imm_sequencer imm_sequencer_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .startReq  (startReq),
  .startPc   (startPc),
  .memAddr   (memAddr),
  .popReq    (popReq),
  .pushValid (pushValid),
  .opValid   (opValid),
  .busy      (busy),
  .doneValid (doneValid),
  .doneStatus(doneStatus)
);

// File: tb/imm_sequencer_bench.sv
module imm_sequencer_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] HALT_OP = 8'h1b; // bench unit faults on this opcode
  localparam logic [7:0] JUMP_OP = 8'h0c; // bench unit redirects on this opcode
  localparam logic [15:0] JUMP_TGT = 16'h0300;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic [15:0] startPc = '0;
  logic stopFlag = 1'b0;
  logic [15:0] memAddr;
  logic [7:0] memData;
  logic popReq;
  logic [7:0] popData = '0;
  logic pushValid, pushRet;
  logic [7:0] pushData;
  logic opValid, opShort, opRet, opKeep;
  logic [4:0] opCode;
  logic opDone = 1'b0, opJump = 1'b0, haltIn = 1'b0;
  logic [15:0] opTarget = JUMP_TGT;
  logic busy, doneValid;
  logic [1:0] doneStatus;
  logic [15:0] faultPc;

  logic [7:0] mem [0:1023];
  assign memData = mem[memAddr[9:0]];

  always #(CLK_PERIOD/2) clk = ~clk;

  imm_sequencer u_imm_sequencer (
    .clk(clk), .rstN(rstN), .startReq(startReq), .startPc(startPc),
    .stopFlag(stopFlag), .memAddr(memAddr), .memData(memData),
    .popReq(popReq), .popData(popData), .pushValid(pushValid),
    .pushRet(pushRet), .pushData(pushData), .opValid(opValid),
    .opCode(opCode), .opShort(opShort), .opRet(opRet), .opKeep(opKeep),
    .opDone(opDone), .opJump(opJump), .opTarget(opTarget), .haltIn(haltIn),
    .busy(busy), .doneValid(doneValid), .doneStatus(doneStatus),
    .faultPc(faultPc)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  // bench-side stacks and pending actions
  logic [7:0] wst[$];
  logic [7:0] rst[$];
  bit pendPop, pendPush, pendRet, opPend;
  logic [7:0] pendByte, opPendCode;
  int actPops;

  // expected results from the reference interpreter
  logic [8:0] expPush[$];
  logic [7:0] expOps[$];
  int expCycles, expPops;
  logic [1:0] expStatus;
  logic [15:0] expFault;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic clearMem();
    for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
  endtask

  task automatic put(input int addr, input logic [7:0] b);
    mem[addr[9:0]] = b;
  endtask

  function automatic logic [15:0] rd16(input logic [15:0] a);
    return {mem[a[9:0]], mem[10'(a[9:0] + 10'd1)]};
  endfunction

  // behavioural interpreter: predicts pushes, issued ops, pops, cycles, outcome
  task automatic refModel(input logic [15:0] entry, input bit stop);
    logic [7:0] ws[$];
    logic [15:0] pc, off, ret;
    logic [7:0] ins, v;
    expPush.delete(); expOps.delete();
    expPops = 0; expCycles = 1; expFault = '0;
    if (entry == 16'h0 || stop) begin
      expStatus = 2'd3;
      return;
    end
    pc = entry;
    for (int step = 0; step < 400; step++) begin
      ins = mem[pc[9:0]];
      expFault = pc;
      pc = pc + 16'd1;
      if (ins == 8'h00) begin
        expCycles += 1; expStatus = 2'd1; return;
      end else if (ins == 8'h20) begin
        expPops++;
        v = (ws.size() > 0) ? ws.pop_back() : 8'h00;
        if (v == 8'h00) begin pc = pc + 16'd2; expCycles += 1; end
        else begin off = rd16(pc); pc = pc + 16'd2 + off; expCycles += 3; end
      end else if (ins == 8'h40) begin
        off = rd16(pc); pc = pc + 16'd2 + off; expCycles += 3;
      end else if (ins == 8'h60) begin
        off = rd16(pc); ret = pc + 16'd2;
        expPush.push_back({1'b1, ret[15:8]});
        expPush.push_back({1'b1, ret[7:0]});
        pc = ret + off; expCycles += 5;
      end else if (ins == 8'h80 || ins == 8'hC0) begin
        v = mem[pc[9:0]];
        expPush.push_back({ins[6], v});
        if (!ins[6]) ws.push_back(v);
        pc = pc + 16'd1; expCycles += 2;
      end else if (ins == 8'hA0 || ins == 8'hE0) begin
        off = rd16(pc);
        expPush.push_back({ins[6], off[15:8]});
        expPush.push_back({ins[6], off[7:0]});
        if (!ins[6]) begin ws.push_back(off[15:8]); ws.push_back(off[7:0]); end
        pc = pc + 16'd2; expCycles += 5;
      end else begin
        expOps.push_back(ins);
        expCycles += 2;
        if (ins == HALT_OP) begin expStatus = 2'd2; return; end
        if (ins == JUMP_OP) pc = JUMP_TGT;
      end
    end
    expStatus = 2'd0;
  endtask

  // called at each falling edge during a run
  task automatic monitorStep();
    if (pendPop && wst.size() > 0) void'(wst.pop_back());
    if (pendPush) begin
      if (pendRet) rst.push_back(pendByte);
      else         wst.push_back(pendByte);
    end
    opDone = 1'b0; opJump = 1'b0; haltIn = 1'b0;
    if (opPend) begin
      if (opPendCode == HALT_OP) haltIn = 1'b1;
      else begin opDone = 1'b1; opJump = (opPendCode == JUMP_OP); end
      opPend = 1'b0;
    end
    pendPop = popReq; pendPush = pushValid; pendRet = pushRet; pendByte = pushData;
    if (popReq) actPops++;
    if (pushValid) begin
      if (expPush.size() == 0) check("R4/R5/R8 unexpected push", {23'd0, pushRet, pushData}, 32'h1ff);
      else begin
        check("R4/R5/R8 push byte and stack", {23'd0, pushRet, pushData}, {23'd0, expPush[0]});
        void'(expPush.pop_front());
      end
    end
    if (opValid) begin
      opPend = 1'b1;
      opPendCode = {opKeep, opRet, opShort, opCode};
      if (expOps.size() == 0) check("R9 unexpected op", {24'd0, opPendCode}, 32'h1ff);
      else begin
        check("R9 op fields", {24'd0, opPendCode}, {24'd0, expOps[0]});
        void'(expOps.pop_front());
      end
    end
    popData = (wst.size() > 0) ? wst[wst.size()-1] : 8'h00;
  endtask

  task automatic runProgram(input string name, input logic [15:0] entry, input bit stop);
    int n;
    refModel(entry, stop);
    wst.delete(); rst.delete();
    pendPop = 0; pendPush = 0; opPend = 0; actPops = 0;
    popData = 8'h00;
    @(negedge clk);
    startPc = entry; stopFlag = stop; startReq = 1'b1;
    n = 0;
    forever begin
      @(posedge clk); n++;
      @(negedge clk);
      if (n == 1) begin
        startReq = 1'b0;
        if (expStatus != 2'd3) check({name, " R2 first fetch address"}, {16'd0, memAddr}, {16'd0, entry});
        else check({name, " R1 no fetch on refused start"}, {31'd0, busy}, 32'd0);
      end
      monitorStep();
      if (doneValid) break;
      check({name, " R2 busy during run"}, {31'd0, busy}, 32'd1);
      if (n > 3000) begin check({name, " run watchdog"}, 32'd0, 32'd1); break; end
    end
    check({name, " R1/R3/R10 completion status"}, {30'd0, doneStatus}, {30'd0, expStatus});
    check({name, " R4-R8 cycle count"}, n, expCycles);
    check({name, " R7 pops"}, actPops, expPops);
    check({name, " R5/R8 pushes consumed"}, expPush.size(), 0);
    check({name, " R9 ops consumed"}, expOps.size(), 0);
    if (expStatus == 2'd2) check({name, " R10 fault address"}, {16'd0, faultPc}, {16'd0, expFault});
    @(negedge clk);
    opDone = 1'b0; opJump = 1'b0; haltIn = 1'b0;
    check({name, " R12 pulse ends, idle"}, {30'd0, doneValid, busy}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual expired expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    clearMem();
    repeat (3) @(negedge clk);
    check("R11 reset quiet", {28'd0, busy, doneValid, pushValid, opValid}, 32'd0);
    check("R11 reset no pop", {31'd0, popReq}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    // R1: refused starts
    runProgram("r1_zero", 16'h0000, 1'b0);
    put(16'h100, 8'h80); put(16'h101, 8'h11); put(16'h102, 8'h00);
    runProgram("r1_stop", 16'h0100, 1'b1);

    // R3/R4/R5: literals onto both stacks
    clearMem();
    put(16'h100, 8'h80); put(16'h101, 8'h12);
    put(16'h102, 8'hA0); put(16'h103, 8'hAB); put(16'h104, 8'hCD);
    put(16'h105, 8'hC0); put(16'h106, 8'h34);
    put(16'h107, 8'hE0); put(16'h108, 8'h56); put(16'h109, 8'h78);
    put(16'h10A, 8'h00);
    runProgram("r4_r5_literals", 16'h0100, 1'b0);

    // R7: conditional jump, not taken then taken
    clearMem();
    put(16'h100, 8'h80); put(16'h101, 8'h00);
    put(16'h102, 8'h20); put(16'h103, 8'h00); put(16'h104, 8'h05);
    put(16'h105, 8'h80); put(16'h106, 8'h01);
    put(16'h107, 8'h20); put(16'h108, 8'h00); put(16'h109, 8'h02);
    put(16'h10A, 8'h80); put(16'h10B, 8'h99);
    put(16'h10C, 8'h80); put(16'h10D, 8'h07);
    put(16'h10E, 8'h00);
    runProgram("r7_cond", 16'h0100, 1'b0);

    // R8/R6: subroutine jump, then backwards unconditional jump
    clearMem();
    put(16'h100, 8'h60); put(16'h101, 8'h00); put(16'h102, 8'h03);
    put(16'h103, 8'h80); put(16'h104, 8'hAA);
    put(16'h105, 8'h00);
    put(16'h106, 8'h40); put(16'h107, 8'hFF); put(16'h108, 8'hFA);
    runProgram("r8_r6_jumps", 16'h0100, 1'b0);

    // R9: ordinary ops with mode bits, redirect from execution unit
    clearMem();
    put(16'h100, 8'hE5); put(16'h101, 8'h21); put(16'h102, JUMP_OP);
    put(16'h300, 8'h80); put(16'h301, 8'h55); put(16'h302, 8'h00);
    runProgram("r9_ops", 16'h0100, 1'b0);

    // R10: halt from execution unit
    clearMem();
    put(16'h200, 8'h80); put(16'h201, 8'h01); put(16'h202, HALT_OP);
    put(16'h203, 8'h80); put(16'h204, 8'h66);
    runProgram("r10_halt", 16'h0200, 1'b0);

    // R7: empty working stack reads as zero, jump skipped
    clearMem();
    put(16'h080, 8'h20); put(16'h081, 8'h12); put(16'h082, 8'h34);
    put(16'h083, 8'hC0); put(16'h084, 8'h3C); put(16'h085, 8'h00);
    runProgram("r7_empty", 16'h0080, 1'b0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule